// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank

This block models, at logic level, a bank of four 8-bit parallel I/O ports of the kind found on small 8-bit microcontrollers. Every pin has an output latch written by the processor. The block turns that latch into three drive-enable outputs for the pad: a pull-down, a strong pull-up and a weak pull-up. Pad levels come back through a registered input sampler. A port read can take one of two paths. A plain read returns the sampled pin levels. A read-modify-write read returns the latch, so bit updates do not corrupt pins that are being pulled low from outside.

The ports do not all behave the same way. Port 0 is open-drain: in general-purpose use it never pulls up. In external-memory mode it carries the low address byte and the data byte, time-multiplexed, and is driven both ways. In that same mode port 2 carries the high address byte, and its latch is left untouched. Port 3 combines each latch bit with an alternate-function output through an AND. A latch left at 1 therefore lets the alternate signal through. Ports 1 to 3 pulse the strong pull-up for one clock whenever a pin's value rises. They keep the weak pull-up on while the value is 1.

To use a pin as an input, software writes 1 to its latch. The pull-down then turns off and an external source can pull the pin low.

Top module: `qbport_bank`

## Requirements
- R1: A synchronous reset loads every latch with 8'hFF. After reset, every pull-down enable and every strong pull-up enable is 0. The weak pull-up enable is 1 on every pin of ports 1, 2 and 3 and 0 on port 0.
- R2: A write with `wr_en` high stores `wr_data` into the latch of port `wr_sel`. One clock after the latch updates, each 0 bit turns on that pin's pull-down, and the pin's pull-ups are off. A pull-down is never on together with a pull-up on the same pin.
- R3: Outside external-memory mode, port 0 is open-drain. Its strong and weak pull-up enables stay 0 and its pull-down enable equals the inverted latch.
- R4: On ports 1 to 3, when a pin's output value goes from 0 to 1, its strong pull-up enable is 1 for exactly one clock. The weak pull-up enable stays 1 for as long as the value is 1.
- R5: A read with `rd_en` high and `rd_latch` low returns, on `rd_data` one clock later, the pin levels of port `rd_sel` as sampled one clock earlier from `pin_in`. Port p occupies bits [8p+7:8p] of `pin_in`.
- R6: A read with `rd_latch` high returns the latch contents of port `rd_sel`, whatever the pins show.
- R7: The output value of each port 3 pin is the latch bit AND the matching `alt_out` bit. Either one at 0 drives the pin low.
- R8: While `ext_mode` is high, port 2 drives `ext_addr[15:8]` instead of its latch, and its latch keeps its value.
- R9: While `ext_mode` is high, port 0 drives `ext_addr[7:0]` when `ext_addr_phase` is high, or `ext_wdata` when only `ext_data_oe` is high. It drives with both the pull-down (for 0 bits) and the strong pull-up (for 1 bits). With neither phase input high, all three of its enables are 0.
- R10: `ext_rdata` equals the port 0 pin levels sampled at the previous clock.
- R11: `alt_in` equals the port 3 pin levels sampled at the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port selected for the write |
| wr_data | input | 8 | Latch write value |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Port selected for the read |
| rd_latch | input | 1 | 1: read-modify-write path (latch), 0: pin path |
| rd_data | output | 8 | Registered read result |
| pin_in | input | 32 | Pad levels, port p at bits 8p+7..8p |
| alt_out | input | 8 | Alternate-function outputs for port 3 |
| alt_in | output | 8 | Sampled port 3 pins for alternate-function inputs |
| ext_mode | input | 1 | External-memory mode select |
| ext_addr | input | 16 | External-memory address |
| ext_addr_phase | input | 1 | Port 0 carries the low address byte |
| ext_data_oe | input | 1 | Port 0 drives `ext_wdata` |
| ext_wdata | input | 8 | Data byte to drive on port 0 |
| ext_rdata | output | 8 | Sampled port 0 pins for external reads |
| pd_en | output | 32 | Pull-down enables, one per pin |
| spu_en | output | 32 | Strong pull-up enables, one per pin |
| wpu_en | output | 32 | Weak pull-up enables, one per pin |

## Verification
The bench builds the block with its default parameters: four ports of eight bits, a 16-bit address and the fixed port roles. This makes all four drive flavours reachable in one run: open-drain, plain pull-up, address-high and alternate-gated. It writes distinct byte patterns so that the two read paths give different results for the same port. It moves through the address phase, the data phase and the released bus phase, and then checks that the port 2 latch survived the external cycle. It also makes the alternate signal and the latch each force a pin low on their own.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  typedef enum logic [1:0] {
    ROLE_OPEN_DRAIN = 2'd0,
    ROLE_PULLUP     = 2'd1,
    ROLE_ADDR_HI    = 2'd2,
    ROLE_ALT        = 2'd3
  } port_role_e;

  localparam int ADDR_LO_PORT = 0;
  localparam int ADDR_HI_PORT = 2;
  localparam int ALT_PORT     = 3;

  function automatic port_role_e role_of(input int idx);
    if (idx == ADDR_LO_PORT)      return ROLE_OPEN_DRAIN;
    else if (idx == ADDR_HI_PORT) return ROLE_ADDR_HI;
    else if (idx == ALT_PORT)     return ROLE_ALT;
    else                          return ROLE_PULLUP;
  endfunction

endpackage

// File: rtl/qbp_sampler.sv
module qbp_sampler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_smp
);

  always_ff @(posedge clk) begin
    if (rst) pin_smp <= '1;
    else     pin_smp <= pin_in;
  end

endmodule

// File: rtl/qbp_latch_regs.sv
module qbp_latch_regs #(
  parameter int N_PORT = 4,
  parameter int PW     = 8,
  localparam int SELW  = $clog2(N_PORT),
  localparam int TOTW  = N_PORT * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [PW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [SELW-1:0] rd_sel,
  input  logic            rd_latch,
  input  logic [TOTW-1:0] pin_smp,
  output logic [TOTW-1:0] latch_q,
  output logic [PW-1:0]   rd_data
);

  for (genvar p = 0; p < N_PORT; p++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst)
        latch_q[p*PW +: PW] <= '1;
      else if (wr_en && (int'(wr_sel) == p))
        latch_q[p*PW +: PW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_latch ? latch_q[int'(rd_sel)*PW +: PW]
                          : pin_smp[int'(rd_sel)*PW +: PW];
  end

  AST_RESET_ALL_HIGH: assert property (@(posedge clk) rst |=> (latch_q == '1)); // R1

endmodule

// File: rtl/qbp_port_drive.sv
module qbp_port_drive
  import qbp_pkg::*;
#(
  parameter int         PW   = 8,
  parameter port_role_e ROLE = ROLE_PULLUP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] latch,
  input  logic [PW-1:0] alt,
  input  logic          bus_mode,
  input  logic          bus_drive,
  input  logic [PW-1:0] bus_byte,
  output logic [PW-1:0] pd_o,
  output logic [PW-1:0] spu_o,
  output logic [PW-1:0] wpu_o
);

  localparam logic [PW-1:0] WPU_RST = (ROLE == ROLE_OPEN_DRAIN) ? '0 : '1;

  logic [PW-1:0] val, val_q, pd_n, spu_n, wpu_n;

  always_comb begin
    case (ROLE)
      ROLE_OPEN_DRAIN, ROLE_ADDR_HI: val = bus_mode ? bus_byte : latch;
      ROLE_ALT:                      val = latch & alt;
      default:                       val = latch;
    endcase
    if (ROLE == ROLE_OPEN_DRAIN) begin
      wpu_n = '0;
      if (!bus_mode) begin
        pd_n  = ~val;
        spu_n = '0;
      end else if (bus_drive) begin
        pd_n  = ~val;
        spu_n = val;
      end else begin
        pd_n  = '0;
        spu_n = '0;
      end
    end else begin
      pd_n  = ~val;
      wpu_n = val;
      spu_n = val & ~val_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '1;
      pd_o  <= '0;
      spu_o <= '0;
      wpu_o <= WPU_RST;
    end else begin
      val_q <= val;
      pd_o  <= pd_n;
      spu_o <= spu_n;
      wpu_o <= wpu_n;
    end
  end

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
    (pd_o & (spu_o | wpu_o)) == '0); // R2

  if (ROLE == ROLE_OPEN_DRAIN) begin : g_od_chk
    AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (rst)
      !bus_mode |=> (spu_o == '0 && wpu_o == '0)); // R3
  end else begin : g_pu_chk
    AST_SPU_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (spu_o != '0) |=> ((spu_o & $past(spu_o)) == '0)); // R4
    AST_SPU_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
      (spu_o != '0) |-> ((spu_o & ~$past(pd_o)) == '0)); // R4
  end

endmodule

// File: rtl/qbport_bank.sv
module qbport_bank
  import qbp_pkg::*;
#(
  parameter int N_PORT = 4,
  parameter int PW     = 8,
  localparam int SELW  = $clog2(N_PORT),
  localparam int TOTW  = N_PORT * PW,
  localparam int AW    = 2 * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [PW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [SELW-1:0] rd_sel,
  input  logic            rd_latch,
  output logic [PW-1:0]   rd_data,
  input  logic [TOTW-1:0] pin_in,
  input  logic [PW-1:0]   alt_out,
  output logic [PW-1:0]   alt_in,
  input  logic            ext_mode,
  input  logic [AW-1:0]   ext_addr,
  input  logic            ext_addr_phase,
  input  logic            ext_data_oe,
  input  logic [PW-1:0]   ext_wdata,
  output logic [PW-1:0]   ext_rdata,
  output logic [TOTW-1:0] pd_en,
  output logic [TOTW-1:0] spu_en,
  output logic [TOTW-1:0] wpu_en
);

  logic [TOTW-1:0] pin_smp, latch_q;
  logic [PW-1:0]   lo_byte;
  logic            lo_drive;

  assign lo_byte  = ext_addr_phase ? ext_addr[PW-1:0] : ext_wdata;
  assign lo_drive = ext_addr_phase | ext_data_oe;

  qbp_sampler #(.W(TOTW)) u_smp (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_smp(pin_smp)
  );

  qbp_latch_regs #(.N_PORT(N_PORT), .PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_latch(rd_latch),
    .pin_smp(pin_smp), .latch_q(latch_q), .rd_data(rd_data)
  );

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    localparam port_role_e PR = role_of(p);
    qbp_port_drive #(.PW(PW), .ROLE(PR)) u_drv (
      .clk(clk), .rst(rst),
      .latch(latch_q[p*PW +: PW]),
      .alt(alt_out),
      .bus_mode(ext_mode),
      .bus_drive(lo_drive),
      .bus_byte((PR == ROLE_OPEN_DRAIN) ? lo_byte : ext_addr[AW-1:PW]),
      .pd_o(pd_en[p*PW +: PW]),
      .spu_o(spu_en[p*PW +: PW]),
      .wpu_o(wpu_en[p*PW +: PW])
    );
  end

  assign ext_rdata = pin_smp[ADDR_LO_PORT*PW +: PW];
  assign alt_in    = pin_smp[ALT_PORT*PW +: PW];

endmodule

// File: tb/sim_qbport_bank.sv
module sim_qbport_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, rd_latch = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [7:0]  wr_data = '0, alt_out = 8'hFF, ext_wdata = '0;
  logic [7:0]  rd_data, alt_in, ext_rdata;
  logic [31:0] pin_in = '1;
  logic        ext_mode = 1'b0, ext_addr_phase = 1'b0, ext_data_oe = 1'b0;
  logic [15:0] ext_addr = '0;
  logic [31:0] pd_en, spu_en, wpu_en;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qbport_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_latch(rd_latch), .rd_data(rd_data),
    .pin_in(pin_in), .alt_out(alt_out), .alt_in(alt_in),
    .ext_mode(ext_mode), .ext_addr(ext_addr), .ext_addr_phase(ext_addr_phase),
    .ext_data_oe(ext_data_oe), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // latch updates at the write edge, drive outputs one edge later
  task automatic write_port(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
    tick();
  endtask

  task automatic read_port(input logic [1:0] sel, input logic lat, output logic [7:0] d);
    rd_en = 1'b1; rd_sel = sel; rd_latch = lat;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] sl(input logic [31:0] v, input int p);
    return v[p*8 +: 8];
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pd_en after reset", pd_en, 32'h0);
    check("R1 spu_en after reset", spu_en, 32'h0);
    check("R1 wpu_en after reset", wpu_en, 32'hFFFF_FF00);
    read_port(2'd1, 1'b1, d);
    check("R1 port1 latch after reset", {24'h0, d}, 32'hFF);
  endtask

  task automatic t_pullup();
    write_port(2'd1, 8'hA5);
    check("R2 port1 pd", {24'h0, sl(pd_en, 1)}, 32'h5A);
    check("R2 port1 wpu", {24'h0, sl(wpu_en, 1)}, 32'hA5);
    check("R2 other ports untouched pd", {sl(pd_en, 3), sl(pd_en, 2), 8'h0, sl(pd_en, 0)}, 32'h0);
    write_port(2'd1, 8'hFF);
    check("R4 port1 strong pulse", {24'h0, sl(spu_en, 1)}, 32'h5A);
    check("R4 port1 weak on", {24'h0, sl(wpu_en, 1)}, 32'hFF);
    tick();
    check("R4 port1 pulse ends", {24'h0, sl(spu_en, 1)}, 32'h0);
    check("R4 port1 weak stays", {24'h0, sl(wpu_en, 1)}, 32'hFF);
  endtask

  task automatic t_open_drain();
    write_port(2'd0, 8'h3C);
    check("R3 port0 pd", {24'h0, sl(pd_en, 0)}, 32'hC3);
    check("R3 port0 wpu", {24'h0, sl(wpu_en, 0)}, 32'h0);
    write_port(2'd0, 8'hFF);
    check("R3 port0 no strong pulse", {24'h0, sl(spu_en, 0)}, 32'h0);
    check("R3 port0 released", {24'h0, sl(pd_en, 0)}, 32'h0);
  endtask

  task automatic t_alt_and_reads();
    logic [7:0] d;
    alt_out = 8'hF0;
    tick();
    check("R7 alt low pulls pin", {24'h0, sl(pd_en, 3)}, 32'h0F);
    alt_out = 8'hFF;
    write_port(2'd3, 8'h3F);
    check("R7 latch low pulls pin", {24'h0, sl(pd_en, 3)}, 32'hC0);
    check("R7 port3 weak", {24'h0, sl(wpu_en, 3)}, 32'h3F);
    pin_in[31:24] = 8'hAA;
    tick();
    check("R11 alt_in sampled", {24'h0, alt_in}, 32'hAA);
    read_port(2'd3, 1'b0, d);
    check("R5 pin read port3", {24'h0, d}, 32'hAA);
    read_port(2'd3, 1'b1, d);
    check("R6 latch read port3", {24'h0, d}, 32'h3F);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    write_port(2'd2, 8'h0F);
    ext_mode = 1'b1; ext_addr = 16'h12C4; ext_addr_phase = 1'b1;
    tick();
    check("R8 port2 carries addr hi", {24'h0, sl(pd_en, 2)}, 32'hED);
    check("R8 port2 weak addr hi", {24'h0, sl(wpu_en, 2)}, 32'h12);
    check("R9 port0 addr pd", {24'h0, sl(pd_en, 0)}, 32'h3B);
    check("R9 port0 addr strong", {24'h0, sl(spu_en, 0)}, 32'hC4);
    ext_addr_phase = 1'b0; ext_data_oe = 1'b1; ext_wdata = 8'h5E;
    tick();
    check("R9 port0 data pd", {24'h0, sl(pd_en, 0)}, 32'hA1);
    check("R9 port0 data strong", {24'h0, sl(spu_en, 0)}, 32'h5E);
    ext_data_oe = 1'b0;
    pin_in[7:0] = 8'h77;
    tick();
    check("R9 port0 released pd/spu", {16'h0, sl(pd_en, 0), sl(spu_en, 0)}, 32'h0);
    check("R9 port0 released wpu", {24'h0, sl(wpu_en, 0)}, 32'h0);
    check("R10 ext_rdata", {24'h0, ext_rdata}, 32'h77);
    check("R8 port1 unaffected", {24'h0, sl(pd_en, 1)}, 32'h0);
    ext_mode = 1'b0;
    tick();
    read_port(2'd2, 1'b1, d);
    check("R8 port2 latch kept", {24'h0, d}, 32'h0F);
    check("R8 port2 back to latch", {24'h0, sl(pd_en, 2)}, 32'hF0);
    read_port(2'd0, 1'b0, d);
    check("R5 pin read port0", {24'h0, d}, 32'h77);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_pullup();
    t_open_drain();
    t_alt_and_reads();
    t_ext();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule